// File: doc/BRIEF.md
# Execute-Mask Bit-Scan Unit

This scalar unit does one bit-manipulation operation each cycle on a 32-bit or 64-bit operand, as chosen by an opcode. The operations fall into three groups. Two operations act on 4-bit groups of lanes: one spreads any live lane across its whole group, and the other reduces each group to a single bit. One operation counts the zero bits. The remaining operations search for a bit. They find the lowest set bit, the lowest clear bit or the highest set bit, count the leading zeros, or count how far the sign bit repeats below the top of the operand.

A search that finds nothing returns -1. The unit is meant to sit beside a scalar ALU that handles execute masks. A request is presented with `in_valid`. The result appears one clock later with `out_valid` set. A new request can be accepted on every cycle.

Top module: `lane_bitscan`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following cycle shows `out_valid` = 0 and `out_result` = 0.
- R2: `out_valid` is a copy of `in_valid` delayed by one clock. The result of a request appears on the cycle after it is accepted. When `in_valid` is low, `out_result` keeps its value.
- R3: Opcode 0 (group fill): each 4-bit group of the output is 4'hF if any bit of the matching input group is set, and 4'h0 otherwise.
- R4: Opcode 1 (group squash): output bit k is set when any bit of input group k (bits 4k+3..4k) is set. Bits 16 and above are 0.
- R5: Opcode 2: the result is the operand width (32 or 64) minus the number of set bits in the operand.
- R6: Opcode 3: the result is the index of the lowest set bit, or -1 if the operand is zero.
- R7: Opcode 4: the result is the index of the lowest clear bit, or -1 if every bit within the width is one.
- R8: Opcode 5: the result is the index of the highest set bit, or -1 if the operand is zero.
- R9: Opcode 6: the result is the width minus 1 minus the index of the highest set bit, or -1 if the operand is zero.
- R10: Opcode 7: the result is the number of bits that match the sign bit, counted from the top and including the sign bit, before the first differing bit. The result is -1 if the operand is all zeros or all ones.
- R11: When `in_wide` = 0, operand bits 63..32 have no effect and the width is 32. Mask results (opcodes 0 and 1) are zero-extended. Count and index results are signed 32-bit values sign-extended to 64 bits, so -1 appears as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Operation select, coded 0..7 as in R3-R10 |
| in_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| in_operand | input | 64 | Operand |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Registered result |

## Verification
The unit holds only one pipeline register, so a wrong internal value reaches `out_result` on the cycle after the faulty request and affects nothing later. A fault in a scanner or in the width masking shows up as a wrong index or a missing -1 for operands whose set bits sit at either end of the word. Those operands are therefore checked in both widths. Faults in the valid or hold logic show up either as a result that changes while `in_valid` is low or as a mismatch between back-to-back requests.

// File: rtl/lane_bitscan_pkg.sv
// Shared opcode type and sizes for the bit-scan unit.
// Assumes the operand width is a multiple of four.
package lane_bitscan_pkg;

    typedef enum logic [2:0] {
        OP_GROUP_FILL   = 3'd0,
        OP_GROUP_SQUASH = 3'd1,
        OP_ZERO_COUNT   = 3'd2,
        OP_LOW_ONE      = 3'd3,
        OP_LOW_ZERO     = 3'd4,
        OP_HIGH_ONE     = 3'd5,
        OP_LEAD_ZEROS   = 3'd6,
        OP_SIGN_RUN     = 3'd7
    } scan_op_e;

    localparam int unsigned IDX_RES_W = 32;

endpackage

// File: rtl/lane_bitscan_group.sv
// Group (nibble) operations: fill every 4-bit group that has any bit set,
// and squash each group to one bit. Assumes W is a multiple of 4.
module lane_bitscan_group #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] fill,
    output logic [W-1:0] squash
);
    localparam int unsigned GROUPS = W / 4;

    // one reduction per group, shared by both outputs
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic any_set;
        assign any_set          = |vec[4*g +: 4];
        assign fill[4*g +: 4]   = {4{any_set}};
        assign squash[g]        = any_set;
    end

    // squash output above the group count is zero
    assign squash[W-1:GROUPS] = '0;

endmodule

// File: rtl/lane_bitscan_locate.sv
// Priority locator: reports whether any bit is set and the index of the
// lowest (MSB_FIRST = 0) or highest (MSB_FIRST = 1) set bit.
// Assumes idx is don't-care when found is 0 (it is driven to 0).
module lane_bitscan_locate #(
    parameter int unsigned W         = 64,
    parameter bit          MSB_FIRST = 1'b0,
    localparam int unsigned IW       = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    assign found = |vec;

    if (MSB_FIRST) begin : g_high
        // walk upward so the highest set bit wins
        always_comb begin
            idx = '0;
            for (int i = 0; i < W; i++) begin
                if (vec[i]) idx = IW'(i);
            end
        end
    end else begin : g_low
        // walk downward so the lowest set bit wins
        always_comb begin
            idx = '0;
            for (int i = W - 1; i >= 0; i--) begin
                if (vec[i]) idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lane_bitscan_popcnt.sv
// Population count of a W-bit vector. Purely combinational.
module lane_bitscan_popcnt #(
    parameter int unsigned W  = 64,
    localparam int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    // add up the set bits
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(vec[i]);
        end
    end

endmodule

// File: rtl/lane_bitscan.sv
// Bit-scan unit top. It masks the operand to the selected width, runs the
// group, count and locate logic in parallel, picks one result by opcode and
// registers it together with a valid flag. It assumes a synchronous
// active-low reset and that DATA_W = 2 * NARROW_W.
module lane_bitscan
    import lane_bitscan_pkg::*;
#(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_operand,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int unsigned IW = $clog2(DATA_W);
    localparam int unsigned CW = $clog2(DATA_W + 1);
    localparam int unsigned RW = IDX_RES_W;
    localparam logic signed [RW-1:0] NONE = '1;

    scan_op_e          op;
    logic [DATA_W-1:0] width_mask, opnd, inv, sign_free;
    logic              sign_bit;
    logic [RW-1:0]     width_val;

    assign op         = scan_op_e'(in_op);
    assign width_mask = in_wide ? '1 : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    assign width_val  = in_wide ? RW'(DATA_W) : RW'(NARROW_W);
    assign opnd       = in_operand & width_mask;
    assign inv        = ~in_operand & width_mask;
    assign sign_bit   = in_wide ? in_operand[DATA_W-1] : in_operand[NARROW_W-1];
    // flip negative operands so the sign run becomes a run of leading zeros
    assign sign_free  = sign_bit ? inv : opnd;

    logic [DATA_W-1:0] fill_v, squash_v;
    logic [CW-1:0]     ones;
    logic              lo1_f, lo0_f, hi1_f, hs_f;
    logic [IW-1:0]     lo1_i, lo0_i, hi1_i, hs_i;

    lane_bitscan_group #(.W(DATA_W)) u_group (
        .vec(opnd), .fill(fill_v), .squash(squash_v)
    );

    lane_bitscan_popcnt #(.W(DATA_W)) u_popcnt (
        .vec(opnd), .count(ones)
    );

    lane_bitscan_locate #(.W(DATA_W), .MSB_FIRST(1'b0)) u_low_one (
        .vec(opnd), .found(lo1_f), .idx(lo1_i)
    );

    lane_bitscan_locate #(.W(DATA_W), .MSB_FIRST(1'b0)) u_low_zero (
        .vec(inv), .found(lo0_f), .idx(lo0_i)
    );

    lane_bitscan_locate #(.W(DATA_W), .MSB_FIRST(1'b1)) u_high_one (
        .vec(opnd), .found(hi1_f), .idx(hi1_i)
    );

    lane_bitscan_locate #(.W(DATA_W), .MSB_FIRST(1'b1)) u_high_sign (
        .vec(sign_free), .found(hs_f), .idx(hs_i)
    );

    logic signed [RW-1:0] idx_res;
    logic                 is_mask_op;
    logic [DATA_W-1:0]    next_result;

    // choose the signed count or index for the non-mask opcodes
    always_comb begin
        unique case (op)
            OP_ZERO_COUNT: idx_res = width_val - RW'(ones);
            OP_LOW_ONE:    idx_res = lo1_f ? RW'(lo1_i) : NONE;
            OP_LOW_ZERO:   idx_res = lo0_f ? RW'(lo0_i) : NONE;
            OP_HIGH_ONE:   idx_res = hi1_f ? RW'(hi1_i) : NONE;
            OP_LEAD_ZEROS: idx_res = hi1_f ? (width_val - RW'(1) - RW'(hi1_i)) : NONE;
            OP_SIGN_RUN:   idx_res = hs_f ? (width_val - RW'(1) - RW'(hs_i)) : NONE;
            default:       idx_res = '0;
        endcase
    end

    // merge mask results with sign-extended index results
    always_comb begin
        is_mask_op = (op == OP_GROUP_FILL) || (op == OP_GROUP_SQUASH);
        if (op == OP_GROUP_FILL)
            next_result = fill_v;
        else if (op == OP_GROUP_SQUASH)
            next_result = squash_v;
        else
            next_result = {{(DATA_W-RW){idx_res[RW-1]}}, idx_res};
    end

    // result register: load on a request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_result <= next_result;
        end
    end

endmodule

// File: rtl/lane_bitscan_checker.sv
// Port-level assertions for lane_bitscan, attached by bind.
module lane_bitscan_checker #(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned NARROW_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic              in_wide,
    input logic [DATA_W-1:0] in_operand,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);
    logic op_zero;
    assign op_zero = in_wide ? (in_operand == '0) : (in_operand[NARROW_W-1:0] == '0);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)); // R2

    AST_FILL_WHOLE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd0) |=>
        (out_result[3:0] == 4'h0 || out_result[3:0] == 4'hF)); // R3

    AST_SQUASH_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd1) |=> (out_result[DATA_W-1:DATA_W/4] == '0)); // R4

    AST_ZERO_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd2) |=> (out_result <= DATA_W)); // R5

    AST_LOW_ONE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd3 && op_zero) |=> (out_result == '1)); // R6

    AST_HIGH_ONE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd5 && op_zero) |=> (out_result == '1)); // R8

    AST_NARROW_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide && in_op == 3'd1) |=>
        (out_result[DATA_W-1:NARROW_W/4] == '0)); // R11

endmodule

bind lane_bitscan lane_bitscan_checker #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_wide(in_wide), .in_operand(in_operand),
    .out_valid(out_valid), .out_result(out_result)
);

// File: tb/lane_bitscan_tb.sv
module lane_bitscan_tb;

    localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [2:0]  op;
        logic        wide;
        logic [63:0] opnd;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b1, 64'h0000_0000_8000_0021, 64'h0000_0000_F000_00FF, 4'd3},  // R3
        '{3'd0, 1'b0, 64'hFFFF_0000_0001_0000, 64'h0000_0000_000F_0000, 4'd11}, // R11
        '{3'd1, 1'b1, 64'h8000_0000_0000_0F01, 64'h0000_0000_0000_8005, 4'd4},  // R4
        '{3'd1, 1'b0, 64'hF000_0000_1000_0010, 64'h0000_0000_0000_0082, 4'd4},  // R4
        '{3'd2, 1'b1, 64'h0000_0000_0000_0000, 64'd64,                  4'd5},  // R5
        '{3'd2, 1'b0, 64'hFFFF_FFFF_0000_00FF, 64'd24,                  4'd5},  // R5
        '{3'd2, 1'b1, ALL1,                    64'd0,                   4'd5},  // R5
        '{3'd3, 1'b1, 64'h0000_0100_0000_0000, 64'd40,                  4'd6},  // R6
        '{3'd3, 1'b1, 64'h0000_0000_0000_0000, ALL1,                    4'd6},  // R6
        '{3'd3, 1'b0, 64'h0000_0001_0000_0000, ALL1,                    4'd11}, // R11
        '{3'd4, 1'b1, 64'h0000_0000_0000_00FF, 64'd8,                   4'd7},  // R7
        '{3'd4, 1'b0, 64'h0000_0000_FFFF_FFFF, ALL1,                    4'd7},  // R7
        '{3'd4, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'd32,                  4'd7},  // R7
        '{3'd5, 1'b1, 64'h0000_0000_0000_0001, 64'd0,                   4'd8},  // R8
        '{3'd5, 1'b1, 64'h8000_0000_0000_0000, 64'd63,                  4'd8},  // R8
        '{3'd5, 1'b0, 64'h0000_0000_0000_0000, ALL1,                    4'd8},  // R8
        '{3'd6, 1'b0, 64'h0000_0000_0000_0001, 64'd31,                  4'd9},  // R9
        '{3'd6, 1'b1, 64'h0000_0000_0000_0001, 64'd63,                  4'd9},  // R9
        '{3'd6, 1'b1, 64'h0000_0000_0000_0000, ALL1,                    4'd9},  // R9
        '{3'd7, 1'b0, 64'h0000_0000_0000_0001, 64'd31,                  4'd10}, // R10
        '{3'd7, 1'b0, 64'h0000_0000_F000_0000, 64'd4,                   4'd10}, // R10
        '{3'd7, 1'b1, ALL1,                    ALL1,                    4'd10}, // R10
        '{3'd7, 1'b1, 64'h0000_0000_0000_0000, ALL1,                    4'd10}, // R10
        '{3'd7, 1'b1, 64'hC000_0000_0000_0000, 64'd2,                   4'd10}, // R10
        '{3'd7, 1'b0, 64'h0000_0000_FFFF_FFFF, ALL1,                    4'd11}, // R11
        '{3'd6, 1'b0, 64'hFFFF_FFFF_0000_0000, ALL1,                    4'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic        in_wide = 1'b0;
    logic [63:0] in_operand = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lane_bitscan u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_wide(in_wide), .in_operand(in_operand),
        .out_valid(out_valid), .out_result(out_result)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic wide, input logic [63:0] v);
        @(negedge clk);
        in_valid   = 1'b1;
        in_op      = op;
        in_wide    = wide;
        in_operand = v;
    endtask

    initial begin
        // R1: reset state while held in reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", out_result, 64'd0);
        rst_n = 1'b1;

        // table walk, one request then one idle cycle each
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].wide, VECS[i].opnd);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d vec%0d", VECS[i].req, i), out_result, VECS[i].exp);
            check("R2 valid after request", {63'd0, out_valid}, 64'd1);
        end

        // R2: idle cycle holds result and drops valid despite input change
        in_op      = 3'd3;
        in_wide    = 1'b1;
        in_operand = 64'h10;
        @(negedge clk);
        check("R2 hold result", out_result, ALL1);
        check("R2 idle valid", {63'd0, out_valid}, 64'd0);

        // R2: back-to-back requests
        issue(3'd5, 1'b1, 64'h0000_0000_0000_0100);  // R8 -> 8
        issue(3'd6, 1'b1, 64'h0000_0000_0000_0100);  // R9 -> 55
        check("R2 back-to-back first", out_result, 64'd8);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 back-to-back second", out_result, 64'd55);

        // R11: upper half ignored in narrow mode for fill
        issue(3'd0, 1'b0, 64'hFFFF_FFFF_0000_0000);
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 narrow fill upper ignored", out_result, 64'd0);

        // R1: reset mid-run clears the result
        issue(3'd2, 1'b1, 64'h0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R1 mid-run result", out_result, 64'd0);
        check("R1 mid-run valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule